// File: doc/BRIEF.md
# Quadrature pulse rate scaler

This block sits between a step decoder and a position counter and changes the rate of a stream of direction-tagged steps. Each incoming step is first scaled by a fractional ratio N/2048 through a phase accumulator. Every step that survives this divider is then multiplied into a burst of F output steps, with F between 1 and 32. The burst leaves the block at no more than one step per clock.

Output steps that have been produced but not yet sent are held in a signed backlog. The backlog is a net count, so steps in opposite directions cancel. A stop input has two behaviours, chosen by a mode bit. In one mode the stop discards all pending steps at once. In the other it blocks new input while the steps already received continue to drain.

Top module: `pulse_rate_scaler`

## Requirements
- R1: After reset, stepOut and dirOut are 0, and the phase accumulator and the backlog are empty.
- R2: A step accepted with dirIn=1 adds divRatio to an 11-bit phase modulo 2048 and produces one divided step on carry-out. A step accepted with dirIn=0 subtracts divRatio and produces one divided step on borrow.
- R3: While divRatio is 0, no input step ever produces an output step.
- R4: Each divided step changes the backlog by mulCode+1 steps: upward when dirIn=1, downward when dirIn=0.
- R5: stepOut is high for at most one step per clock. It is high in the cycle after the backlog was non-zero. An input step sampled at clock edge k can appear on stepOut no earlier than after edge k+1.
- R6: The backlog is a signed net count, so steps in opposite directions cancel. dirOut is 1 for a step that moves the backlog down from a positive value and 0 otherwise. dirOut holds its value while no step is emitted.
- R7: While stopCmd=1 and drainOnStop=0, input steps are ignored, the backlog is cleared, and stepOut is 0 in the next cycle.
- R8: While stopCmd=1 and drainOnStop=1, input steps are ignored and leave the phase unchanged, and the backlog keeps draining one step per clock.
- R9: The backlog saturates at ±(2^(BACKLOG_W-1)-1). Steps beyond that limit are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stepIn | input | 1 | One input step per cycle high |
| dirIn | input | 1 | Direction of stepIn (1 = up) |
| divRatio | input | DIV_W | Divider numerator N; the ratio is N/2048 |
| mulCode | input | MUL_W | Multiplication factor minus one |
| stopCmd | input | 1 | Stop request (level) |
| drainOnStop | input | 1 | 1 = stop drains the pending steps, 0 = stop discards them |
| stepOut | output | 1 | Scaled output step |
| dirOut | output | 1 | Direction of stepOut (1 = up) |

## Verification
The bench builds the block with BACKLOG_W=8, which gives a backlog limit of ±127. At that width, a short burst with N=2047 and factor 32 drives the backlog into saturation within a few cycles. The divider and multiplier keep their full default widths, so the carry and borrow behaviour of the 11-bit phase is exercised over its real range. The bench also covers both stop modes and direction reversals.

// File: rtl/prs_pkg.sv
package prs_pkg;
  typedef struct packed {
    logic accept;  // input step enters the phase accumulator
    logic clear;   // discard the backlog and suppress the output
    logic emit;    // send one backlog step this cycle
  } prs_ctl_t;
endpackage

// File: rtl/prs_ctrl.sv
module prs_ctrl
  import prs_pkg::*;
(
  input  logic     stepIn,
  input  logic     stopCmd,
  input  logic     drainOnStop,
  input  logic     backlogBusy,
  output prs_ctl_t ctl
);
  always_comb begin
    ctl.accept = stepIn && !stopCmd;
    ctl.clear  = stopCmd && !drainOnStop;
    ctl.emit   = backlogBusy && !ctl.clear;
  end
endmodule

// File: rtl/prs_datapath.sv
module prs_datapath
  import prs_pkg::*;
#(
  parameter int DIV_W     = 11,
  parameter int MUL_W     = 5,
  parameter int BACKLOG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  prs_ctl_t         ctl,
  input  logic             dirIn,
  input  logic [DIV_W-1:0] divRatio,
  input  logic [MUL_W-1:0] mulCode,
  output logic             backlogBusy,
  output logic             stepOut,
  output logic             dirOut
);
  localparam int SUM_W = BACKLOG_W + 2;
  localparam int MSB   = BACKLOG_W - 1;
  localparam logic signed [SUM_W-1:0] HI_LIM = SUM_W'((1 << (BACKLOG_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] LO_LIM = -HI_LIM;

  logic [DIV_W-1:0]            phase, phaseNext;
  logic [DIV_W:0]              upSum, downDiff;
  logic                        divided;
  logic signed [BACKLOG_W-1:0] backlog, backlogNext;
  logic signed [SUM_W-1:0]     wide, factorS, clipped;

  // fractional divider: carry (up) or borrow (down) of the phase
  always_comb begin
    upSum     = {1'b0, phase} + {1'b0, divRatio};
    downDiff  = {1'b0, phase} - {1'b0, divRatio};
    phaseNext = dirIn ? upSum[DIV_W-1:0] : downDiff[DIV_W-1:0];
    divided   = ctl.accept && (dirIn ? upSum[DIV_W] : downDiff[DIV_W]);
  end

  // signed backlog update with saturation
  always_comb begin
    factorS = {{(SUM_W-MUL_W){1'b0}}, mulCode} + SUM_W'(1);
    wide    = SUM_W'(backlog);
    if (ctl.emit) begin
      if (backlog[MSB]) wide = wide + SUM_W'(1);
      else              wide = wide - SUM_W'(1);
    end
    if (divided) begin
      if (dirIn) wide = wide + factorS;
      else       wide = wide - factorS;
    end
    if (wide > HI_LIM)      clipped = HI_LIM;
    else if (wide < LO_LIM) clipped = LO_LIM;
    else                    clipped = wide;
    backlogNext = ctl.clear ? '0 : clipped[BACKLOG_W-1:0];
  end

  assign backlogBusy = (backlog != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= '0;
      backlog <= '0;
      stepOut <= 1'b0;
      dirOut  <= 1'b0;
    end else begin
      if (ctl.accept) phase <= phaseNext;
      backlog <= backlogNext;
      stepOut <= ctl.emit;
      if (ctl.emit) dirOut <= !backlog[MSB];
    end
  end

  p_quiet_when_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (backlog == '0) |=> !stepOut);
  p_busy_sends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (backlogBusy && !ctl.clear) |=> stepOut);
  p_stop_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.clear |=> (backlog == '0 && !stepOut));
  p_dir_follows_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stepOut |-> (dirOut == !$past(backlog[MSB])));
  p_zero_div_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.accept && divRatio == '0) |-> !divided);
  p_no_min_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(backlog[MSB] && backlog[MSB-1:0] == '0));
endmodule

// File: rtl/pulse_rate_scaler.sv
module pulse_rate_scaler
  import prs_pkg::*;
#(
  parameter int DIV_W     = 11,
  parameter int MUL_W     = 5,
  parameter int BACKLOG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stepIn,
  input  logic             dirIn,
  input  logic [DIV_W-1:0] divRatio,
  input  logic [MUL_W-1:0] mulCode,
  input  logic             stopCmd,
  input  logic             drainOnStop,
  output logic             stepOut,
  output logic             dirOut
);
  prs_ctl_t ctl;
  logic     backlogBusy;

  prs_ctrl u_ctrl (
    .stepIn      (stepIn),
    .stopCmd     (stopCmd),
    .drainOnStop (drainOnStop),
    .backlogBusy (backlogBusy),
    .ctl         (ctl)
  );

  prs_datapath #(
    .DIV_W     (DIV_W),
    .MUL_W     (MUL_W),
    .BACKLOG_W (BACKLOG_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl         (ctl),
    .dirIn       (dirIn),
    .divRatio    (divRatio),
    .mulCode     (mulCode),
    .backlogBusy (backlogBusy),
    .stepOut     (stepOut),
    .dirOut      (dirOut)
  );

  p_one_way_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stopCmd && !drainOnStop) |=> !stepOut);
endmodule

// File: tb/sim_pulse_rate_scaler.sv
`timescale 1ns/1ps
module sim_pulse_rate_scaler;
  localparam int BW  = 8;
  localparam int LIM = (1 << (BW - 1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stepIn = 1'b0, dirIn = 1'b0, stopCmd = 1'b0, drainOnStop = 1'b0;
  logic [10:0] divRatio = '0;
  logic [4:0]  mulCode = '0;
  logic stepOut, dirOut;

  int compared = 0, mismatched = 0;
  int mAcc = 0, mBl = 0;
  logic expStep = 1'b0, expDir = 1'b0;
  int outCount = 0;

  always #2 clk = ~clk;

  pulse_rate_scaler #(.DIV_W(11), .MUL_W(5), .BACKLOG_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .stepIn(stepIn), .dirIn(dirIn),
    .divRatio(divRatio), .mulCode(mulCode), .stopCmd(stopCmd),
    .drainOnStop(drainOnStop), .stepOut(stepOut), .dirOut(dirOut));

  task automatic check(input logic act, input logic exp, input string what, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural model of one clock edge, then compare after the edge
  task automatic tick(input logic s, input logic d, input logic st, input logic dr, input string tag);
    int nb;
    stepIn = s; dirIn = d; stopCmd = st; drainOnStop = dr;
    @(posedge clk);
    if (st && !dr) begin
      expStep = 1'b0; mBl = 0;
    end else begin
      expStep = (mBl != 0);
      if (expStep) expDir = (mBl > 0);
      nb = mBl - (expStep ? ((mBl > 0) ? 1 : -1) : 0);
      if (s && !st) begin
        if (d) begin
          mAcc += int'(divRatio);
          if (mAcc >= 2048) begin mAcc -= 2048; nb += int'(mulCode) + 1; end
        end else begin
          mAcc -= int'(divRatio);
          if (mAcc < 0) begin mAcc += 2048; nb -= int'(mulCode) + 1; end
        end
      end
      if (nb > LIM) nb = LIM;
      if (nb < -LIM) nb = -LIM;
      mBl = nb;
    end
    @(negedge clk);
    check(stepOut, expStep, "stepOut", tag);
    if (expStep) check(dirOut, expDir, "dirOut", tag);
    if (stepOut) outCount++;
  endtask

  initial begin
    #(200000 * 4);
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(stepOut, 1'b0, "reset stepOut", "R1");
    check(dirOut, 1'b0, "reset dirOut", "R1");

    // R2 / R4: divide by half, factor 1, upward
    divRatio = 11'd1024; mulCode = 5'd0;
    for (int i = 0; i < 12; i++) tick(1'b1, 1'b1, 1'b0, 1'b0, "R2");
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b1, 1'b0, 1'b0, "R5");
    // R2 downward with an odd ratio and factor 3
    divRatio = 11'd700; mulCode = 5'd2;
    for (int i = 0; i < 20; i++) tick(i % 2 == 0, 1'b0, 1'b0, 1'b0, "R4");
    for (int i = 0; i < 30; i++) tick(1'b0, 1'b0, 1'b0, 1'b0, "R6");

    // R3: zero ratio passes nothing
    divRatio = 11'd0; mulCode = 5'd31;
    outCount = 0;
    for (int i = 0; i < 40; i++) tick(1'b1, i[0], 1'b0, 1'b0, "R3");
    check(outCount == 0, 1'b1, "no output with ratio 0", "R3");

    // R6: reversal cancels pending steps
    divRatio = 11'd2047; mulCode = 5'd4;
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b1, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 20; i++) tick(1'b0, 1'b0, 1'b0, 1'b0, "R6");

    // R9: saturate the backlog, then R7 discard it
    mulCode = 5'd31;
    for (int i = 0; i < 10; i++) tick(1'b1, 1'b1, 1'b0, 1'b0, "R9");
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b1, 1'b0, 1'b0, "R9");
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b1, 1'b1, 1'b0, "R7");
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b1, 1'b0, 1'b0, "R7");

    // R8: stop with drain keeps sending, input ignored
    mulCode = 5'd3;
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, 1'b0, 1'b0, "R8");
    outCount = 0;
    for (int i = 0; i < 40; i++) tick(1'b1, 1'b0, 1'b1, 1'b1, "R8");
    check(outCount > 0, 1'b1, "drain produced steps", "R8");
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b0, 1'b0, 1'b0, "R8");

    // mixed random traffic
    for (int i = 0; i < 2000; i++) begin
      if (i % 100 == 0) begin
        divRatio = 11'($urandom_range(0, 2047));
        mulCode  = 5'($urandom_range(0, 31));
      end
      tick(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0),
           $urandom_range(0, 19) == 0, 1'($urandom_range(0, 1)), "R5");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule